// File: doc/BRIEF.md
# Cyclic Majority-Logic Decoder for the (7,3) Difference-Set Code

This block corrects a 7-bit hard-decision word of the (7,3) cyclic code that is built on the difference set {0,2,3}. The code has 3 information bits and a minimum distance of 4. After a start pulse the block copies the received word into a circular register. It then runs seven decode steps. In each step three parity sums are formed, and each of them checks the bit that currently sits at the top of the register. A two-of-three vote on these sums decides whether that bit is wrong. The bit is then corrected, and the register rotates by one place.

Because the code is cyclic, one vote circuit is enough for every bit position and no syndrome table is needed. After the seventh step the register has returned to its starting alignment. The block pulses `done` for one clock and holds the corrected word on its output until the next accepted start.

Top module: `mlg_cyclic_dec`

## Requirements
- R1: While reset is held and right after it, `busy` and `done` are 0 and `dec_word` is 0.
- R2: A start seen while the block is idle loads `rx_word` into the register. From the next clock `busy` is 1 and `dec_word` equals the loaded word. `busy` stays high for exactly 7 clocks.
- R3: `done` is 1 for exactly one clock, the clock right after the seventh step, and `busy` is 0 in that clock.
- R4: When `rx_word` is a codeword, the output equals the input. Bit i of a word is position i+1. A word is a codeword when every cyclic rotation of the bit set {3,4,6} has even parity over that word.
- R5: Any word that differs from a codeword in exactly one bit is decoded to that codeword.
- R6: Each step works on register bit 6. It forms the sums s1 = b3^b4^b6, s2 = b1^b5^b6 and s3 = b0^b2^b6, and inverts b6 when at least two of them are 1. The (possibly inverted) bit then goes to bit 0 while bits 5..0 move up by one. The output after 7 steps equals this procedure for every input, including words with several errors.
- R7: A start that arrives while `busy` is 1 is ignored. The running decode and its result are unchanged.
- R8: While idle and without start, `dec_word` holds its value.
- R9: A start in the same clock as `done` is accepted. The new word is loaded and `busy` rises on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding `rx_word` (honoured only when idle) |
| rx_word | input | 7 | Received hard-decision word, bit i = position i+1 |
| dec_word | output | 7 | Contents of the decode register; the corrected word once `done` is seen |
| busy | output | 1 | High during the seven decode steps |
| done | output | 1 | One-clock strobe marking a finished decode |

## Verification
Two events can fall in the same clock: the `done` strobe of one word and the acceptance of the next word's start. The bench raises start in exactly the clock where `done` is high. It reads the finished result in that clock, and on the following clock it checks that `done` has dropped, `busy` has risen and the new word is loaded. The second decode is then judged in full against the reference procedure. A start that arrives during `busy` is likewise placed inside a running decode, and the result must match the uninterrupted reference.

// File: rtl/mlg_cyclic_dec.sv
module mlg_cyclic_dec (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [6:0] rx_word,
  output logic [6:0] dec_word,
  output logic       busy,
  output logic       done
);
  localparam int N  = 7;
  localparam int CW = $clog2(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [N-1:0]  sreg;
  logic [CW-1:0] step;

  wire s1   = sreg[3] ^ sreg[4] ^ sreg[6];
  wire s2   = sreg[1] ^ sreg[5] ^ sreg[6];
  wire s3   = sreg[0] ^ sreg[2] ^ sreg[6];
  wire flip = (s1 & s2) | (s1 & s3) | (s2 & s3);
  wire [N-1:0] nxt = {sreg[N-2:0], sreg[N-1] ^ flip};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      step <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          sreg <= rx_word;
          step <= '0;
          busy <= 1'b1;
        end
      end else begin
        sreg <= nxt;
        if (step == LAST) begin
          step <= '0;
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  assign dec_word = sreg;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && dec_word == $past(rx_word)));
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != LAST) |=> busy);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(dec_word));
endmodule

// File: tb/mlg_cyclic_dec_tb.sv
module mlg_cyclic_dec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] rx_word = '0;
  logic [6:0] dec_word;
  logic       busy, done;
  int n_chk = 0, n_bad = 0;
  logic [6:0] cw_tab [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  mlg_cyclic_dec dut_i (.clk(clk), .rst_n(rst_n), .start(start), .rx_word(rx_word),
                        .dec_word(dec_word), .busy(busy), .done(done));

  function automatic logic [6:0] rotl(input logic [6:0] w, input int k);
    logic [6:0] r = w;
    for (int i = 0; i < k; i++) r = {r[5:0], r[6]};
    return r;
  endfunction

  function automatic bit is_cw(input logic [6:0] w);
    for (int k = 0; k < 7; k++)
      if (^(w & rotl(7'b1011000, k))) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [6:0] ref_dec(input logic [6:0] w);
    logic [6:0] b = w;
    for (int t = 0; t < 7; t++) begin
      int cnt;
      cnt = int'(b[3]^b[4]^b[6]) + int'(b[1]^b[5]^b[6]) + int'(b[0]^b[2]^b[6]);
      b = {b[5:0], (cnt >= 2) ? ~b[6] : b[6]};
    end
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // caller is at a negedge; leaves at the negedge where done is high
  task automatic decode(input logic [6:0] w, input bit inject, input logic [6:0] expw, input string req);
    int k = 0;
    start = 1'b1; rx_word = w;
    @(negedge clk);
    start = 1'b0;
    chk(busy && dec_word == w, "R2 load", {busy, dec_word[5:0]}, {1'b1, w[5:0]});
    while (!done && k < 20) begin
      @(negedge clk);
      k++;
      if (inject && k == 1) begin start = 1'b1; rx_word = ~w; end
      if (k == 2) start = 1'b0;
    end
    chk(k == 7, "R2 busy length", 7'(k), 7'd7);
    chk(done && !busy, "R3 done strobe", {5'b0, done, busy}, 7'b10);
    chk(dec_word == ref_dec(w), "R6 procedure", dec_word, ref_dec(w));
    chk(dec_word == expw, req, dec_word, expw);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int nc = 0;
    void'($urandom(32'h5eed_1234));
    for (int v = 0; v < 128; v++)
      if (is_cw(7'(v)) && nc < 8) begin cw_tab[nc] = 7'(v); nc++; end
    chk(nc == 8, "R4 codeword count", 7'(nc), 7'd8);

    repeat (3) @(negedge clk);
    chk(!busy && !done && dec_word == '0, "R1 reset", {busy, done, dec_word[4:0]}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && dec_word == '0, "R1 after reset", {busy, done, dec_word[4:0]}, '0);

    // R4: every codeword passes unchanged
    for (int i = 0; i < 8; i++) begin
      decode(cw_tab[i], 1'b0, cw_tab[i], "R4 codeword");
      @(negedge clk);
      chk(!done, "R3 single pulse", {6'b0, done}, '0);
    end

    // R5: every single-bit error of every codeword
    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 7; p++) begin
        decode(cw_tab[i] ^ (7'b1 << p), 1'b0, cw_tab[i], "R5 single error");
        @(negedge clk);
      end

    // R7: start during busy ignored
    for (int i = 0; i < 8; i++) begin
      logic [6:0] w;
      w = cw_tab[$urandom % 8] ^ (7'b1 << ($urandom % 7));
      decode(w, 1'b1, ref_dec(w), "R7 start ignored");
      @(negedge clk);
    end

    // R8: output held while idle
    begin
      logic [6:0] held;
      held = dec_word;
      rx_word = ~held;
      repeat (5) @(negedge clk);
      chk(dec_word == held && !busy, "R8 idle hold", dec_word, held);
    end

    // R9 + R6: back-to-back on done, multi-error random words
    begin
      logic [6:0] w0, w1;
      w0 = 7'($urandom);
      decode(w0, 1'b0, ref_dec(w0), "R6 random");
      for (int i = 0; i < 40; i++) begin
        logic [6:0] e;
        e = 7'($urandom) & 7'($urandom);
        w1 = cw_tab[$urandom % 8] ^ e;
        start = 1'b1; rx_word = w1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && dec_word == w1, "R9 start on done", dec_word, w1);
        while (!done) @(negedge clk);
        chk(dec_word == ref_dec(w1), "R6 multi-error", dec_word, ref_dec(w1));
      end
      @(negedge clk);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule